// File: doc/BRIEF.md
# Sequenced Square-Plus-Double Datapath

This block computes y = x·x + 2·x for an unsigned input x. It does this with a small datapath and a four-step controller instead of dedicated arithmetic. The datapath has two working registers, A and B. It has one ALU that either adds or multiplies, a mux that picks what the registers load (the input x or the ALU result), and a mux that picks the ALU's second operand (register A or register B). The ALU's first operand is always register A.

The controller steps through four phases:

1. Capture x into both registers.
2. Square B in place.
3. Double A in place.
4. Present A + B on the result port.

Each phase advances only on a cycle where `go` is high. A cycle with `go` low freezes the controller and both registers, so the caller can pace or pause the computation at any point. The result is twice as wide as x, so it never overflows.

`done` is high for exactly the final step's cycle. During that cycle `result` carries the sum. In every other cycle `result` reads zero. The controller then returns to its wait phase, and a `go` held high starts the next computation at once.

Top module: `poly_seq_top`

## Requirements
- R1: A synchronous active-high `rst` returns the controller to its wait phase from any step. While it is in that phase, `done` is 0 and `result` is 0. The first computation after reset completes after the normal four `go` cycles.
- R2: When `go` is high on four consecutive cycles starting in the wait phase, `done` is high in the fourth of those cycles and low in the first three.
- R3: In the cycle where `done` is high, `result` equals x·x + 2·x. This holds for every W-bit x, including 0 and 2^W−1 (2^W−1 gives 2^(2W)−1 with no wrap).
- R4: `done` is never high for two consecutive cycles, and it is only high in a cycle where `go` is high. Whenever `done` is 0, `result` is 0.
- R5: A cycle with `go` low, in any of the four steps, changes neither the step nor either register. A stall of n cycles delays `done` by n cycles and leaves the final result unchanged. This includes a stall in the final step, where `done` stays 0 until `go` returns.
- R6: x is sampled only in the first step, on the rising edge where `go` is high in the wait phase; that edge loads x into both registers. Changes to x during the later steps do not affect the result.
- R7: While the controller waits with `go` low, `done` stays 0, for any number of cycles.
- R8: If `go` stays high after a `done` cycle, the next computation starts on the following cycle. Results come out every four cycles, and each one is correct for the x captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Advance enable; low stalls the sequence |
| x | input | W | Unsigned operand, sampled in the first step |
| result | output | 2W | x·x + 2·x while `done` is high, zero otherwise |
| done | output | 1 | High for the single cycle that carries the result |

## Verification
The two events that can coincide are the arrival of the final step and a stall request. If `go` drops exactly when the controller reaches its summing step, the result must be held back: `done` must not appear. The bench provokes this by stalling in each of the four steps, including the last, for several cycles. In every stalled cycle it checks that `done` and `result` stay at zero, and it checks that the result, once released, is the same as an unstalled run. A second overlap, the `done` of one computation followed immediately by the capture for the next, is provoked by holding `go` high across two back-to-back operands.

// File: rtl/poly_pkg.sv
package poly_pkg;

    // Controller phases; the wait phase doubles as the capture step.
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_SQUARE = 2'd1,
        ST_DOUBLE = 2'd2,
        ST_SUM    = 2'd3
    } step_e;

    // ALU operation code: 0 adds, 1 multiplies.
    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_MUL = 1'b1
    } alu_op_e;

    // Control word from the sequencer to the datapath.
    typedef struct packed {
        logic    src_alu;    // register write source: 0 = input x, 1 = ALU
        logic    b_from_rb;  // ALU operand B: 0 = register A, 1 = register B
        alu_op_e op;
        logic    ld_a;
        logic    ld_b;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        src_alu:   1'b1,
        b_from_rb: 1'b1,
        op:        ALU_ADD,
        ld_a:      1'b0,
        ld_b:      1'b0
    };

endpackage

// File: rtl/poly_alu.sv
module poly_alu
    import poly_pkg::*;
#(
    parameter int RW = 16
) (
    input  alu_op_e        op,
    input  logic [RW-1:0]  a,
    input  logic [RW-1:0]  b,
    output logic [RW-1:0]  y
);

    always_comb begin
        case (op)
            ALU_MUL: y = a * b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/poly_datapath.sv
module poly_datapath
    import poly_pkg::*;
#(
    parameter int W  = 8,
    parameter int RW = 2 * W
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctl,
    input  logic [W-1:0]   x,
    output logic [RW-1:0]  ra_q,
    output logic [RW-1:0]  rb_q,
    output logic [RW-1:0]  alu_y
);

    logic [RW-1:0] opnd_b;
    logic [RW-1:0] wdata;

    assign opnd_b = ctl.b_from_rb ? rb_q : ra_q;

    poly_alu #(.RW(RW)) u_alu (
        .op (ctl.op),
        .a  (ra_q),
        .b  (opnd_b),
        .y  (alu_y)
    );

    assign wdata = ctl.src_alu ? alu_y : RW'(x);

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
        end else begin
            if (ctl.ld_a) ra_q <= wdata;
            if (ctl.ld_b) rb_q <= wdata;
        end
    end

endmodule

// File: rtl/poly_ctrl.sv
module poly_ctrl
    import poly_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    output step_e  state_q,
    output ctrl_t  ctl,
    output logic   done
);

    step_e state_d;

    always_comb begin
        state_d = state_q;
        ctl     = CTRL_IDLE;
        done    = 1'b0;
        case (state_q)
            ST_WAIT: begin
                ctl.src_alu = 1'b0;
                if (go) begin
                    ctl.ld_a = 1'b1;
                    ctl.ld_b = 1'b1;
                    state_d  = ST_SQUARE;
                end
            end
            ST_SQUARE: begin
                ctl.op        = ALU_MUL;
                ctl.b_from_rb = 1'b1;
                if (go) begin
                    ctl.ld_b = 1'b1;
                    state_d  = ST_DOUBLE;
                end
            end
            ST_DOUBLE: begin
                ctl.op        = ALU_ADD;
                ctl.b_from_rb = 1'b0;
                if (go) begin
                    ctl.ld_a = 1'b1;
                    state_d  = ST_SUM;
                end
            end
            default: begin
                ctl.op        = ALU_ADD;
                ctl.b_from_rb = 1'b1;
                if (go) begin
                    done    = 1'b1;
                    state_d = ST_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/poly_seq_top.sv
module poly_seq_top
    import poly_pkg::*;
#(
    parameter int W = 8,
    localparam int RW = 2 * W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [W-1:0]   x,
    output logic [RW-1:0]  result,
    output logic           done
);

    step_e         state_q;
    ctrl_t         ctl;
    logic [RW-1:0] ra_q;
    logic [RW-1:0] rb_q;
    logic [RW-1:0] alu_y;

    poly_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .state_q (state_q),
        .ctl     (ctl),
        .done    (done)
    );

    poly_datapath #(.W(W), .RW(RW)) u_dp (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .x     (x),
        .ra_q  (ra_q),
        .rb_q  (rb_q),
        .alu_y (alu_y)
    );

    assign result = done ? alu_y : '0;

endmodule

// File: rtl/poly_seq_checker.sv
module poly_seq_checker
    import poly_pkg::*;
#(
    parameter int W  = 8,
    parameter int RW = 2 * W
) (
    input logic           clk,
    input logic           rst,
    input logic           go,
    input logic [W-1:0]   x,
    input logic [RW-1:0]  result,
    input logic           done,
    input step_e          state_q,
    input logic [RW-1:0]  ra_q,
    input logic [RW-1:0]  rb_q
);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !go |=> ($stable(state_q) && $stable(ra_q) && $stable(rb_q)));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_needs_go_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> go);

    assert_zero_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !done |-> (result == '0));

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        (go && state_q == ST_WAIT) |=> ((ra_q == RW'($past(x))) && (rb_q == RW'($past(x)))));

    assert_done_order_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(state_q) == ST_DOUBLE || $past(state_q) == ST_SUM));

    assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> !done);

endmodule

bind poly_seq_top poly_seq_checker #(.W(W), .RW(RW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .x       (x),
    .result  (result),
    .done    (done),
    .state_q (state_q),
    .ra_q    (ra_q),
    .rb_q    (rb_q)
);

// File: tb/poly_seq_top_bench.sv
module poly_seq_top_bench;

    localparam int W  = 8;
    localparam int RW = 2 * W;
    localparam int NV = 8;

    // operand, expected result, stall step (0 = none), stall length
    localparam logic [W-1:0]  TX [NV] = '{8'd0, 8'd1, 8'd2, 8'd15, 8'd100, 8'd200, 8'd254, 8'd255};
    localparam logic [RW-1:0] TY [NV] = '{16'd0, 16'd3, 16'd8, 16'd255, 16'd10200, 16'd40400, 16'd65024, 16'd65535};
    localparam int            TS [NV] = '{0, 1, 2, 3, 4, 0, 4, 2};
    localparam int            TL [NV] = '{0, 3, 1, 2, 5, 0, 1, 4};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          go  = 1'b0;
    logic [W-1:0]  x   = '0;
    logic [RW-1:0] result;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    poly_seq_top #(.W(W)) u_poly_seq_top (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .x      (x),
        .result (result),
        .done   (done)
    );

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One computation; called at a negedge, returns at a negedge with go low.
    task automatic run_op(input logic [W-1:0] v, input logic [RW-1:0] exp,
                          input int stall_at, input int stall_len);
        x  = v;
        go = 1'b1;
        for (int s = 1; s <= 4; s++) begin
            if (s == stall_at) begin
                go = 1'b0;
                for (int k = 0; k < stall_len; k++) begin
                    #1;
                    check("R5 done low while stalled", {15'd0, done}, 16'd0);
                    check("R5 result zero while stalled", result, 16'd0);
                    @(posedge clk); @(negedge clk);
                end
                go = 1'b1;
            end
            #1;
            if (s == 4) begin
                check("R2 done in fourth go cycle", {15'd0, done}, 16'd1);
                check("R3 result value", result, exp);
            end else begin
                check("R2 done low before fourth step", {15'd0, done}, 16'd0);
            end
            @(posedge clk); @(negedge clk);
            if (s == 1) x = ~v;   // R6: later x changes must not matter
        end
        go = 1'b0;
        #1;
        check("R4 done single cycle", {15'd0, done}, 16'd0);
        check("R4 result zero after done", result, 16'd0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset done", {15'd0, done}, 16'd0);
        check("R1 reset result", result, 16'd0);

        // table walk: values, stalls in every step (R3, R5, R6)
        for (int i = 0; i < NV; i++) run_op(TX[i], TY[i], TS[i], TL[i]);

        // R7: long wait with go low
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); @(negedge clk); #1;
            check("R7 idle done low", {15'd0, done}, 16'd0);
        end
        run_op(8'd9, 16'd99, 0, 0);

        // R8: go held high across two operations
        run_op(8'd3, 16'd15, 0, 0);
        run_op(8'd128, 16'd16640, 0, 0);

        // R1: reset in the middle of a computation
        x  = 8'd50;
        go = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        go  = 1'b0;
        #1;
        check("R1 mid-run reset done", {15'd0, done}, 16'd0);
        check("R1 mid-run reset result", result, 16'd0);
        run_op(8'd7, 16'd63, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule